// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block derives a slower clock from its input clock. The ratio is set by a small divisor code held in a register. A separate gate bit switches the derived clock on and off. Software uses a plain write/read register port. It writes a divisor code, then polls a status word until the busy indication drops. Once busy is low, the new ratio is in force at the output.

The divisor code is `DIV_W` bits wide, with a default of 5. A code of zero does not mean bypass. It selects the largest ratio, 2^`DIV_W`. When `EXT_MODE` is set, the top code bit works as a multiply-by-64 flag that applies to the lower bits. This reaches large ratios with a short field. Ratio changes wait for the end of the current output period, so the output never shows a shortened pulse. Gate changes take effect only while the output is low.

Every output period starts with its high phase. The high phase lasts floor(R/2) input cycles and the low phase lasts the rest. `DATA_W` must be at least 5 and at least `DIV_W`.

Top module: `clk_ratio_gate`

## Requirements
- R1: After reset, `clk_o` is low, the divisor code reads 0, the gate bit reads 0 and the status word reads 0.
- R2: With `EXT_MODE`=0, a divisor code n with 2 <= n <= 2^`DIV_W`-1 gives an output period of exactly n input cycles.
- R3: Divisor code 0 gives a period of 2^`DIV_W` input cycles (32 at the default width). This is also the ratio in force after reset.
- R4: Divisor code 1 is raised to ratio 2, because the output is a registered signal.
- R5: With `EXT_MODE`=1, code bit `DIV_W`-1 is the scale flag. With the flag set and a nonzero low field L, the ratio is 64*L. With the flag set and L=0, the ratio is 64*2^(`DIV_W`-1) (2048 for a 6-bit field). With the flag clear, the code is decoded as in R2 to R4, so code 0 gives 2^`DIV_W`.
- R6: For ratio R, each output high phase lasts floor(R/2) input cycles and each low phase lasts R-floor(R/2).
- R7: Gate register (address 1, bit 0). While the gate is 0, `clk_o` stays low. Setting it to 1 restarts whole pulses. Reading address 1 returns the written bit.
- R8: A gate change made during a high phase lets that high phase run to its full length. The gate switches only while the output is low.
- R9: Status register (address 2). Bits 3 and 4 both go high from the clock edge that accepts a divisor write (address 0). They clear on the edge that ends the output period in progress, and the new ratio starts from that edge.
- R10: An output period that is running when the divisor is rewritten finishes with its old high and low lengths. The new period starts directly after it, high first.
- R11: Address 0 stores the low `DIV_W` bits of the written data and reads them back zero-extended. Writes to addresses 2 and 3 change no register and do not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| wr_addr_i | input | 2 | Write address: 0 divisor, 1 gate, 2 status, 3 unused |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 2 | Read address, same map as writes |
| rd_data_o | output | DATA_W | Combinational read data for `rd_addr_i` |
| clk_o | output | 1 | Divided and gated output clock |

## Verification
The hardest cases to reach from the ports are a rewrite of the divisor, or a clearing of the gate, at a chosen point inside a running output period. The stimulus first watches `clk_o` at falling input-clock edges until it sees the first high sample of a pulse. It then writes within that same cycle. With a known old ratio of 8, the bench can predict the exact number of busy samples (7). It can also predict the remaining high and low counts of the old period and the high start of the new one. The largest extended ratio of 2048 is measured as a whole period, after a wait on the busy bits that spans one old period.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DIV  = 2'd0,
    SEL_GATE = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // status word positions of the two busy flags
  localparam int BUSY_BIT_A = 3;
  localparam int BUSY_BIT_B = 4;

  // bits needed for the largest ratio of a given field
  function automatic int ratio_bits(input int div_w, input bit ext);
    return ext ? div_w + 6 : div_w + 1;
  endfunction
endpackage

// File: rtl/clk_ratio_decode.sv
module clk_ratio_decode #(
  parameter int DIV_W    = 5,
  parameter bit EXT_MODE = 1'b0,
  parameter int RATIO_W  = 6
) (
  input  logic [DIV_W-1:0]   code_i,
  output logic [RATIO_W-1:0] ratio_o
);
  localparam logic [RATIO_W-1:0] ZERO_RATIO = RATIO_W'(1) << DIV_W;
  localparam logic [RATIO_W-1:0] MIN_RATIO  = RATIO_W'(2);

  logic [RATIO_W-1:0] plain_ratio;

  always_comb begin
    if (code_i == '0)                    plain_ratio = ZERO_RATIO;
    else if (code_i == DIV_W'(1))        plain_ratio = MIN_RATIO;
    else                                 plain_ratio = RATIO_W'(code_i);
  end

  generate
    if (EXT_MODE) begin : g_scaled
      localparam logic [RATIO_W-1:0] TOP_RATIO = RATIO_W'(1) << (DIV_W + 5);
      logic               scale_flag;
      logic [DIV_W-2:0]   low_field;
      assign scale_flag = code_i[DIV_W-1];
      assign low_field  = code_i[DIV_W-2:0];
      always_comb begin
        if (!scale_flag)              ratio_o = plain_ratio;
        else if (low_field == '0)     ratio_o = TOP_RATIO;
        else                          ratio_o = RATIO_W'({low_field, 6'b000000});
      end
    end else begin : g_plain
      assign ratio_o = plain_ratio;
    end
  endgenerate
endmodule

// File: rtl/clk_ratio_regs.sv
module clk_ratio_regs
  import clk_ratio_pkg::*;
#(
  parameter int DIV_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              upd_ack_i,
  output logic [DIV_W-1:0]  code_o,
  output logic              gate_o,
  output logic              pend_o
);
  logic [DIV_W-1:0] code_q;
  logic             gate_q;
  logic             pend_q;
  logic             wr_code, wr_gate;
  logic             unused_hi_bits;

  assign wr_code = wr_en_i && (wr_addr_i == SEL_DIV);
  assign wr_gate = wr_en_i && (wr_addr_i == SEL_GATE);
  assign unused_hi_bits = ^wr_data_i[DATA_W-1:DIV_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      gate_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_code) code_q <= wr_data_i[DIV_W-1:0];
      if (wr_gate) gate_q <= wr_data_i[0];
      // a fresh write outranks an acknowledge of the older value
      if (wr_code)        pend_q <= 1'b1;
      else if (upd_ack_i) pend_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      SEL_DIV:  rd_data_o = DATA_W'(code_q);
      SEL_GATE: rd_data_o[0] = gate_q;
      SEL_STAT: begin
        rd_data_o[BUSY_BIT_A] = pend_q;
        rd_data_o[BUSY_BIT_B] = pend_q;
      end
      default:  rd_data_o = '0;
    endcase
  end

  assign code_o = code_q;
  assign gate_o = gate_q;
  assign pend_o = pend_q;

  assert_busy_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == SEL_DIV) |=> pend_q);
  assert_busy_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_q) |-> $past(upd_ack_i));
  assert_stat_write_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == SEL_STAT) |=> ($stable(code_q) && $stable(gate_q)));
endmodule

// File: rtl/clk_ratio_core.sv
module clk_ratio_core #(
  parameter int RATIO_W = 6,
  parameter logic [RATIO_W-1:0] RST_RATIO = 6'd32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_new_i,
  input  logic               upd_req_i,
  output logic               upd_ack_o,
  input  logic               gate_en_i,
  output logic               clk_o
);
  logic [RATIO_W-1:0] ratio_q, cnt_q;
  logic [RATIO_W-1:0] ratio_n, cnt_n;
  logic               wrap, phase_n, gate_q, out_q;

  assign wrap      = (cnt_q == ratio_q - RATIO_W'(1));
  assign upd_ack_o = wrap && upd_req_i;
  assign ratio_n   = upd_ack_o ? ratio_new_i : ratio_q;
  assign cnt_n     = wrap ? '0 : cnt_q + RATIO_W'(1);
  assign phase_n   = cnt_n < (ratio_n >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= RST_RATIO;
      cnt_q   <= '0;
      gate_q  <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      ratio_q <= ratio_n;
      cnt_q   <= cnt_n;
      // the gate follows its request only across a low phase
      if (!phase_n) gate_q <= gate_en_i;
      out_q   <= phase_n && gate_q;
    end
  end

  assign clk_o = out_q;

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_q);
  assert_ratio_floor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_q >= RATIO_W'(2));
  assert_switch_at_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ratio_q) |-> ($past(wrap) && cnt_q == '0));
  assert_gate_while_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gate_q) |-> !out_q);
endmodule

// File: rtl/clk_ratio_gate.sv
module clk_ratio_gate
  import clk_ratio_pkg::*;
#(
  parameter int DIV_W    = 5,
  parameter bit EXT_MODE = 1'b0,
  parameter int DATA_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              clk_o
);
  localparam int RATIO_W = ratio_bits(DIV_W, EXT_MODE);
  localparam logic [RATIO_W-1:0] RST_RATIO = RATIO_W'(1) << DIV_W;

  logic [DIV_W-1:0]   code;
  logic [RATIO_W-1:0] ratio_new;
  logic               gate_en, pend, upd_ack;

  clk_ratio_regs #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .upd_ack_i (upd_ack),
    .code_o    (code),
    .gate_o    (gate_en),
    .pend_o    (pend)
  );

  clk_ratio_decode #(.DIV_W(DIV_W), .EXT_MODE(EXT_MODE), .RATIO_W(RATIO_W)) u_decode (
    .code_i  (code),
    .ratio_o (ratio_new)
  );

  clk_ratio_core #(.RATIO_W(RATIO_W), .RST_RATIO(RST_RATIO)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ratio_new_i (ratio_new),
    .upd_req_i   (pend),
    .upd_ack_o   (upd_ack),
    .gate_en_i   (gate_en),
    .clk_o       (clk_o)
  );
endmodule

// File: tb/clk_ratio_gate_tb.sv
module clk_ratio_gate_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en_s   [2];
  logic [1:0] wr_addr_s [2];
  logic [7:0] wr_data_s [2];
  logic [1:0] rd_addr_s [2];
  logic [7:0] rd_data_s [2];
  logic       clko_s    [2];
  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_ratio_gate #(.DIV_W(5), .EXT_MODE(1'b0), .DATA_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en_s[0]), .wr_addr_i(wr_addr_s[0]),
    .wr_data_i(wr_data_s[0]), .rd_addr_i(rd_addr_s[0]), .rd_data_o(rd_data_s[0]),
    .clk_o(clko_s[0]));

  clk_ratio_gate #(.DIV_W(6), .EXT_MODE(1'b1), .DATA_W(8)) u_dut_ext (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en_s[1]), .wr_addr_i(wr_addr_s[1]),
    .wr_data_i(wr_data_s[1]), .rd_addr_i(rd_addr_s[1]), .rd_data_o(rd_data_s[1]),
    .clk_o(clko_s[1]));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  task automatic wr(input int d, input logic [1:0] a, input logic [7:0] v);
    wr_en_s[d] = 1'b1; wr_addr_s[d] = a; wr_data_s[d] = v;
    @(negedge clk);
    wr_en_s[d] = 1'b0;
  endtask

  task automatic rd(input int d, input logic [1:0] a, output int v);
    rd_addr_s[d] = a;
    #1;
    v = int'(rd_data_s[d]);
  endtask

  task automatic wait_idle(input int d);
    int s;
    rd(d, 2'd2, s);
    for (int i = 0; i < 5000 && s != 0; i++) begin
      @(negedge clk);
      rd(d, 2'd2, s);
    end
  endtask

  task automatic measure(input int d, output int hi, output int per);
    int lo;
    while (clko_s[d]) @(negedge clk);
    while (!clko_s[d]) @(negedge clk);
    hi = 0;
    while (clko_s[d]) begin hi++; @(negedge clk); end
    lo = 0;
    while (!clko_s[d]) begin lo++; @(negedge clk); end
    per = hi + lo;
  endtask

  task automatic sync_rise(input int d);
    while (clko_s[d]) @(negedge clk);
    while (!clko_s[d]) @(negedge clk);
  endtask

  task automatic ratio_case(input int d, input int code, input int ratio, input string req);
    int hi, per;
    wr(d, 2'd0, 8'(code));
    wait_idle(d);
    measure(d, hi, per);
    check(per == ratio, req, per, ratio);
    check(hi == ratio / 2, "R6", hi, ratio / 2);
  endtask

  task automatic t_reset();
    int v;
    for (int d = 0; d < 2; d++) begin
      check(clko_s[d] == 1'b0, "R1", int'(clko_s[d]), 0);
      rd(d, 2'd0, v); check(v == 0, "R1", v, 0);
      rd(d, 2'd1, v); check(v == 0, "R1", v, 0);
      rd(d, 2'd2, v); check(v == 0, "R1", v, 0);
    end
  endtask

  task automatic t_gate_off_idle();
    int highs = 0;
    for (int i = 0; i < 80; i++) begin
      if (clko_s[0]) highs++;
      @(negedge clk);
    end
    check(highs == 0, "R7", highs, 0);
  endtask

  task automatic t_zero_code();
    int hi, per, v;
    wr(0, 2'd1, 8'h01);
    rd(0, 2'd1, v); check(v == 1, "R7", v, 1);
    measure(0, hi, per);
    check(per == 32, "R3", per, 32);
    check(hi == 16, "R6", hi, 16);
  endtask

  task automatic t_std_ratios();
    ratio_case(0, 2, 2, "R2");
    ratio_case(0, 5, 5, "R2");
    ratio_case(0, 8, 8, "R2");
    ratio_case(0, 31, 31, "R2");
    ratio_case(0, 1, 2, "R4");
    ratio_case(0, 0, 32, "R3");
  endtask

  task automatic t_busy_midcycle();
    int busy = 0, lows = 0, s, hi, per;
    ratio_case(0, 8, 8, "R2");
    sync_rise(0);
    wr(0, 2'd0, 8'd4);
    rd(0, 2'd2, s);
    check(s == 8'h18, "R9", s, 8'h18);
    for (int i = 0; i < 100 && s != 0; i++) begin
      busy++;
      if (!clko_s[0]) lows++;
      @(negedge clk);
      rd(0, 2'd2, s);
    end
    check(busy == 7, "R9", busy, 7);
    check(lows == 4, "R10", lows, 4);
    check(clko_s[0] == 1'b1, "R10", int'(clko_s[0]), 1);
    measure(0, hi, per);
    check(per == 4, "R9", per, 4);
  endtask

  task automatic t_gate_midhigh();
    int hi = 1, lows = 0, per;
    ratio_case(0, 8, 8, "R2");
    sync_rise(0);
    wr(0, 2'd1, 8'h00);
    while (clko_s[0] && hi < 50) begin hi++; @(negedge clk); end
    check(hi == 4, "R8", hi, 4);
    for (int i = 0; i < 30; i++) begin
      if (!clko_s[0]) lows++;
      @(negedge clk);
    end
    check(lows == 30, "R7", lows, 30);
    wr(0, 2'd1, 8'h01);
    measure(0, hi, per);
    check(hi == 4, "R8", hi, 4);
    check(per == 8, "R7", per, 8);
  endtask

  task automatic t_map();
    int v, hi, per;
    wr(0, 2'd0, 8'hE5);
    rd(0, 2'd0, v); check(v == 5, "R11", v, 5);
    wait_idle(0);
    wr(0, 2'd2, 8'hFF);
    rd(0, 2'd2, v); check(v == 0, "R11", v, 0);
    wr(0, 2'd3, 8'hFF);
    rd(0, 2'd0, v); check(v == 5, "R11", v, 5);
    rd(0, 2'd1, v); check(v == 1, "R11", v, 1);
    measure(0, hi, per);
    check(per == 5, "R11", per, 5);
  endtask

  task automatic t_ext();
    wr(1, 2'd1, 8'h01);
    ratio_case(1, 8'h07, 7, "R5");
    ratio_case(1, 8'h22, 128, "R5");
    ratio_case(1, 8'h20, 2048, "R5");
    ratio_case(1, 8'h00, 64, "R5");
    ratio_case(1, 8'h01, 2, "R5");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      wr_en_s[d] = 1'b0; wr_addr_s[d] = '0; wr_data_s[d] = '0; rd_addr_s[d] = '0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_gate_off_idle();
    t_zero_code();
    t_std_ratios();
    t_busy_midcycle();
    t_gate_midhigh();
    t_map();
    t_ext();
    summary();
  end
endmodule